// File: doc/BRIEF.md
# Null-Page Trap and Boot ROM Overlay

This block sits on a processor's data path in front of the system bus. It can catch data loads and stores that hit the lowest 4 KB of the physical address space, and it can make every data read of the boot ROM return a programmable 32-bit word instead of ROM contents. A three-entry register bank holds the trap control, the overlay enable and the overlay word. Instruction fetches are never trapped and never substituted.

A request is decoded in the cycle it is presented. Forwarded requests appear on the downstream side in the same cycle. The downstream side answers one cycle later, and its response is passed back unchanged. Requests the block answers itself get a response in the following cycle: trapped accesses, substituted reads and dropped ROM writes. A trapped access carries an error flag and a one-cycle trap pulse.

The boot ROM region is 64 KB at the top of the address space. It also has an alias at address zero. The region base, the region size and the alias are all parameters.

Top module: `null_trap_overlay`

## Requirements
- R1: After reset, config index 0 (trap control) reads 0x00010000. Config index 1 (overlay control) and index 2 (overlay word) read 0.
- R2: In trap control, only bit 0 (trap enable) and bit 16 (spare) are stored, and all other bits read 0. Bit 16 has no effect on any access.
- R3: With trap enable set, a data read or write to 0x0000–0x0FFF is not forwarded. In the next cycle the block gives rsp_valid=1, rsp_err=1 and rsp_rdata=0, and trap_pulse is high for that single cycle.
- R4: The trap range ends at 0x0FFF, so an access to 0x1000 is forwarded. An instruction fetch to a trapped address is also forwarded.
- R5: With trap enable clear, a data access to 0x0000–0x0FFF is forwarded like any other access.
- R6: With overlay control bit 0 set, a data read in 0xFFFF0000–0xFFFFFFFF or in the alias 0x00000000–0x0000FFFF is not forwarded. In the next cycle it returns the overlay word with rsp_err=0.
- R7: The overlay does not apply to instruction fetches or to addresses outside the ROM region (0xFFFEFFFC, 0x00010000). Those are forwarded.
- R8: A data write to the ROM region is never forwarded, whether the overlay is on or off. It is answered in the next cycle with rsp_valid=1 and rsp_err=0.
- R9: Where the trap range and the ROM alias overlap, the trap takes priority over the overlay.
- R10: Config index 3 reads 0. A written overlay word reads back in full at index 2.
- R11: For a forwarded access, rsp_valid, rsp_err and rsp_rdata equal the downstream response. dn_valid is only high with req_valid, and it carries the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_idx | input | 2 | Config register index |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data (combinational) |
| req_valid | input | 1 | Processor request valid |
| req_write | input | 1 | Request is a write |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_addr | input | 32 | Request physical address |
| req_wdata | input | 32 | Request write data |
| dn_valid | output | 1 | Forwarded request valid |
| dn_write | output | 1 | Forwarded request is a write |
| dn_addr | output | 32 | Forwarded address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_err | input | 1 | Downstream error |
| dn_rsp_rdata | input | 32 | Downstream read data |
| rsp_valid | output | 1 | Response to processor valid |
| rsp_err | output | 1 | Response error |
| rsp_rdata | output | 32 | Response read data |
| trap_pulse | output | 1 | One-cycle null-page trap indication |

## Verification
The assertions check on every cycle these properties:
- A trapped access never leaves on the downstream side, and it is followed by an error response with the pulse.
- A pulse only follows a data access to the low page.
- Fetches are always forwarded.
- No ROM write ever reaches the bus.
- A substituted read returns the overlay word.

Only the bench scenarios show the register reset values, the field masking and the inert spare bit. They also cover the exact edges of the trap range and the ROM region, and the single-cycle width of the pulse across idle cycles.

// File: rtl/nto_pkg.sv
package nto_pkg;
   typedef enum logic [2:0] {
      K_IDLE = 3'd0,
      K_PASS = 3'd1,
      K_TRAP = 3'd2,
      K_OVL  = 3'd3,
      K_DROP = 3'd4
   } acc_kind_e;

   localparam int unsigned IDX_TRAP = 0;
   localparam int unsigned IDX_OVC  = 1;
   localparam int unsigned IDX_OVW  = 2;
   localparam int unsigned SPARE_BIT = 16;
endpackage

// File: rtl/nto_cfg_regs.sv
module nto_cfg_regs
   import nto_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              trap_en,
   output logic              ov_en,
   output logic [DATA_W-1:0] ov_word
);
   logic trap_bit_q, spare_q, ov_en_q;
   logic [DATA_W-1:0] ov_word_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_bit_q <= 1'b0;
         spare_q    <= 1'b1;
         ov_en_q    <= 1'b0;
         ov_word_q  <= '0;
      end else if (we) begin
         case (idx)
            2'(IDX_TRAP): begin
               trap_bit_q <= wdata[0];
               spare_q    <= wdata[SPARE_BIT];
            end
            2'(IDX_OVC): ov_en_q   <= wdata[0];
            2'(IDX_OVW): ov_word_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (idx)
         2'(IDX_TRAP): begin
            rdata[0]         = trap_bit_q;
            rdata[SPARE_BIT] = spare_q;
         end
         2'(IDX_OVC): rdata[0] = ov_en_q;
         2'(IDX_OVW): rdata = ov_word_q;
         default: rdata = '0;
      endcase
   end

   assign trap_en = trap_bit_q;
   assign ov_en   = ov_en_q;
   assign ov_word = ov_word_q;
endmodule

// File: rtl/nto_decode.sv
module nto_decode
   import nto_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned TRAP_LOG2 = 12,
   parameter int unsigned ROM_LOG2  = 16,
   parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFF_0000,
   parameter bit LOW_ALIAS = 1'b1
) (
   input  logic                        valid,
   input  logic                        write,
   input  logic                        fetch,
   input  logic [ADDR_W-TRAP_LOG2-1:0] addr_hi,
   input  logic                        trap_en,
   input  logic                        ov_en,
   output acc_kind_e                   kind
);
   localparam int unsigned HI_W  = ADDR_W - TRAP_LOG2;
   localparam int unsigned ROM_SH = ROM_LOG2 - TRAP_LOG2;
   localparam logic [ADDR_W-ROM_LOG2-1:0] ROM_TAG = ROM_BASE[ADDR_W-1:ROM_LOG2];

   logic null_hit, rom_hi_hit, rom_lo_hit, rom_hit, data_acc;

   assign null_hit   = (addr_hi == {HI_W{1'b0}});
   assign rom_hi_hit = (addr_hi[HI_W-1:ROM_SH] == ROM_TAG);

   generate
      if (LOW_ALIAS) begin : g_alias
         assign rom_lo_hit = (addr_hi[HI_W-1:ROM_SH] == '0);
      end else begin : g_no_alias
         assign rom_lo_hit = 1'b0;
      end
   endgenerate

   assign rom_hit  = rom_hi_hit | rom_lo_hit;
   assign data_acc = valid & ~fetch;

   always_comb begin
      if (!valid)                          kind = K_IDLE;
      else if (data_acc && trap_en && null_hit) kind = K_TRAP;
      else if (data_acc && write && rom_hit)    kind = K_DROP;
      else if (data_acc && !write && ov_en && rom_hit) kind = K_OVL;
      else                                 kind = K_PASS;
   end
endmodule

// File: rtl/nto_resp.sv
module nto_resp
   import nto_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic [DATA_W-1:0] ov_word,
   input  logic              dn_rsp_valid,
   input  logic              dn_rsp_err,
   input  logic [DATA_W-1:0] dn_rsp_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              trap_pulse
);
   acc_kind_e kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n) kind_q <= K_IDLE;
      else        kind_q <= kind;
   end

   always_comb begin
      rsp_valid = 1'b0;
      rsp_err   = 1'b0;
      rsp_rdata = '0;
      case (kind_q)
         K_TRAP: begin
            rsp_valid = 1'b1;
            rsp_err   = 1'b1;
         end
         K_OVL: begin
            rsp_valid = 1'b1;
            rsp_rdata = ov_word;
         end
         K_DROP: rsp_valid = 1'b1;
         default: begin
            rsp_valid = dn_rsp_valid;
            rsp_err   = dn_rsp_err;
            rsp_rdata = dn_rsp_rdata;
         end
      endcase
   end

   assign trap_pulse = (kind_q == K_TRAP);
endmodule

// File: rtl/null_trap_overlay.sv
module null_trap_overlay
   import nto_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TRAP_LOG2 = 12,
   parameter int unsigned ROM_LOG2  = 16,
   parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFF_0000,
   parameter bit LOW_ALIAS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_idx,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              dn_valid,
   output logic              dn_write,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rsp_valid,
   input  logic              dn_rsp_err,
   input  logic [DATA_W-1:0] dn_rsp_rdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              trap_pulse
);
   localparam logic [ADDR_W-1:0] ROM_MASK = (ADDR_W)'((64'd1 << ROM_LOG2) - 64'd1);

   generate
      if (DATA_W <= SPARE_BIT) begin : g_bad_dw
         $error("DATA_W must hold the spare trap-control bit");
      end
      if (TRAP_LOG2 >= ROM_LOG2 || ROM_LOG2 >= ADDR_W) begin : g_bad_rng
         $error("trap range must be smaller than ROM region, ROM region smaller than space");
      end
      if ((ROM_BASE & ROM_MASK) != '0) begin : g_bad_base
         $error("ROM_BASE must be aligned to the region size");
      end
   endgenerate

   logic              trap_en, ov_en;
   logic [DATA_W-1:0] ov_word;
   acc_kind_e         kind;

   nto_cfg_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
      .rdata(cfg_rdata), .trap_en(trap_en), .ov_en(ov_en), .ov_word(ov_word)
   );

   nto_decode #(
      .ADDR_W(ADDR_W), .TRAP_LOG2(TRAP_LOG2), .ROM_LOG2(ROM_LOG2),
      .ROM_BASE(ROM_BASE), .LOW_ALIAS(LOW_ALIAS)
   ) u_dec (
      .valid(req_valid), .write(req_write), .fetch(req_fetch),
      .addr_hi(req_addr[ADDR_W-1:TRAP_LOG2]), .trap_en(trap_en), .ov_en(ov_en),
      .kind(kind)
   );

   nto_resp #(.DATA_W(DATA_W)) u_rsp (
      .clk(clk), .rst_n(rst_n), .kind(kind), .ov_word(ov_word),
      .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .trap_pulse(trap_pulse)
   );

   assign dn_valid = (kind == K_PASS);
   assign dn_write = req_write;
   assign dn_addr  = req_addr;
   assign dn_wdata = req_wdata;
endmodule

// File: rtl/null_trap_overlay_chk.sv
module null_trap_overlay_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TRAP_LOG2 = 12,
   parameter int unsigned ROM_LOG2  = 16,
   parameter logic [ADDR_W-1:0] ROM_BASE = 32'hFFFF_0000,
   parameter bit LOW_ALIAS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_fetch,
   input logic [ADDR_W-1:0] req_addr,
   input logic              dn_valid,
   input logic              dn_write,
   input logic [ADDR_W-1:0] dn_addr,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              trap_pulse,
   input logic              trap_en,
   input logic              ov_en,
   input logic [DATA_W-1:0] ov_word
);
   localparam logic [ADDR_W-1:0] TRAP_END = (ADDR_W)'(64'd1 << TRAP_LOG2);
   localparam logic [ADDR_W-1:0] RMASK    = ~((ADDR_W)'((64'd1 << ROM_LOG2) - 64'd1));

   function automatic logic in_rom(input logic [ADDR_W-1:0] a);
      return ((a & RMASK) == ROM_BASE) || (LOW_ALIAS && ((a & RMASK) == '0));
   endfunction

   logic data_req, null_req;
   assign data_req = req_valid && !req_fetch;
   assign null_req = data_req && (req_addr < TRAP_END);

   // R3
   trap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (null_req && trap_en) |-> !dn_valid);
   // R3
   trap_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (null_req && trap_en) |=> (trap_pulse && rsp_valid && rsp_err));
   // R3
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> $past(null_req && trap_en));
   // R4
   fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fetch) |-> dn_valid);
   // R8
   rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_write) |-> !in_rom(dn_addr));
   // R6
   ovl_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_req && !req_write && ov_en && in_rom(req_addr) && !(null_req && trap_en))
      |=> (rsp_valid && !rsp_err && rsp_rdata == ov_word));
   // R11
   fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (req_valid && dn_addr == req_addr));
endmodule

bind null_trap_overlay null_trap_overlay_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_LOG2(TRAP_LOG2), .ROM_LOG2(ROM_LOG2),
   .ROM_BASE(ROM_BASE), .LOW_ALIAS(LOW_ALIAS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_fetch(req_fetch), .req_addr(req_addr), .dn_valid(dn_valid),
   .dn_write(dn_write), .dn_addr(dn_addr), .rsp_valid(rsp_valid),
   .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .trap_pulse(trap_pulse),
   .trap_en(trap_en), .ov_en(ov_en), .ov_word(ov_word)
);

// File: tb/null_trap_overlay_tb.sv
module null_trap_overlay_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        dn_valid, dn_write;
   logic [31:0] dn_addr, dn_wdata;
   logic        dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
   logic [31:0] dn_rsp_rdata = '0;
   logic        rsp_valid, rsp_err, trap_pulse;
   logic [31:0] rsp_rdata;
   int checks = 0, errors = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   null_trap_overlay u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_write(req_write), .req_fetch(req_fetch), .req_addr(req_addr),
      .req_wdata(req_wdata), .dn_valid(dn_valid), .dn_write(dn_write),
      .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid),
      .dn_rsp_err(dn_rsp_err), .dn_rsp_rdata(dn_rsp_rdata), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .trap_pulse(trap_pulse)
   );

   // downstream model: one-cycle latency, read data = ~address, error at 0xBAD00000
   always @(posedge clk) begin
      dn_rsp_valid <= dn_valid;
      dn_rsp_err   <= dn_valid && (dn_addr == 32'hBAD0_0000);
      dn_rsp_rdata <= (dn_valid && !dn_write) ? ~dn_addr : 32'h0;
   end

   task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [1:0] i, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_chk(input string rq, input logic [1:0] i, input logic [31:0] exp);
      @(negedge clk);
      cfg_idx = i;
      #1 check(rq, "cfg read", cfg_rdata, exp);
   endtask

   // one access; checks forwarding, response and a one-cycle pulse
   task automatic access(input string rq, input logic wr, input logic fe, input logic [31:0] a,
                         input logic exp_fwd, input logic exp_err, input logic [31:0] exp_d,
                         input logic exp_trap);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_fetch = fe; req_addr = a; req_wdata = 32'h5A5A_5A5A;
      #1 check(rq, "forwarded", {31'd0, dn_valid}, {31'd0, exp_fwd});
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_write = 1'b0; req_fetch = 1'b0;
      check(rq, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(rq, "rsp_err", {31'd0, rsp_err}, {31'd0, exp_err});
      check(rq, "rsp_rdata", rsp_rdata, exp_d);
      check(rq, "trap_pulse", {31'd0, trap_pulse}, {31'd0, exp_trap});
      @(posedge clk);
      #1 check(rq, "pulse after", {31'd0, trap_pulse}, 32'd0);
   endtask

   task automatic t_reset;
      cfg_chk("R1", 2'd0, 32'h0001_0000);
      cfg_chk("R1", 2'd1, 32'h0);
      cfg_chk("R1", 2'd2, 32'h0);
      cfg_chk("R10", 2'd3, 32'h0);
   endtask

   task automatic t_trap_off;
      access("R5", 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
      access("R5", 1'b1, 1'b0, 32'h0000_0FFC, 1'b0, 1'b0, 32'h0, 1'b0); // in ROM alias: dropped
      access("R7", 1'b0, 1'b0, 32'hFFFF_0000, 1'b1, 1'b0, 32'h0000_FFFF, 1'b0);
      access("R11", 1'b0, 1'b0, 32'hBAD0_0000, 1'b1, 1'b1, 32'h452F_FFFF, 1'b0);
   endtask

   task automatic t_trap_fields;
      cfg_wr(2'd0, 32'hFFFF_FFFF);
      cfg_chk("R2", 2'd0, 32'h0001_0001);
      cfg_wr(2'd0, 32'h0);
      cfg_chk("R2", 2'd0, 32'h0);
      cfg_wr(2'd0, 32'h0001_0000);
      access("R2", 1'b0, 1'b0, 32'h0000_0010, 1'b1, 1'b0, 32'hFFFF_FFEF, 1'b0);
   endtask

   task automatic t_trap_on;
      cfg_wr(2'd0, 32'h0000_0001);
      access("R3", 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0, 1'b1);
      access("R3", 1'b1, 1'b0, 32'h0000_0FFC, 1'b0, 1'b1, 32'h0, 1'b1);
      access("R4", 1'b0, 1'b0, 32'h0000_1000, 1'b1, 1'b0, 32'hFFFF_EFFF, 1'b0);
      access("R4", 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
   endtask

   task automatic t_overlay;
      cfg_wr(2'd2, 32'hCAFE_F00D);
      cfg_chk("R10", 2'd2, 32'hCAFE_F00D);
      cfg_wr(2'd1, 32'h0000_0001);
      cfg_chk("R10", 2'd1, 32'h1);
      access("R6", 1'b0, 1'b0, 32'hFFFF_1234, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0);
      access("R6", 1'b0, 1'b0, 32'h0000_8000, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0);
      access("R7", 1'b0, 1'b0, 32'hFFFE_FFFC, 1'b1, 1'b0, 32'h0001_0003, 1'b0);
      access("R7", 1'b0, 1'b0, 32'h0001_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b0);
      access("R7", 1'b0, 1'b1, 32'hFFFF_0000, 1'b1, 1'b0, 32'h0000_FFFF, 1'b0);
      access("R9", 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b1, 32'h0, 1'b1);
   endtask

   task automatic t_rom_write;
      access("R8", 1'b1, 1'b0, 32'hFFFF_0010, 1'b0, 1'b0, 32'h0, 1'b0);
      access("R8", 1'b1, 1'b0, 32'h0000_2000, 1'b0, 1'b0, 32'h0, 1'b0);
      cfg_wr(2'd1, 32'h0);
      access("R8", 1'b1, 1'b0, 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0, 1'b0);
      access("R8", 1'b1, 1'b0, 32'h0002_0000, 1'b1, 1'b0, 32'h0, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_trap_off();
      t_trap_fields();
      t_trap_on();
      t_overlay();
      t_rom_write();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule